// File: doc/BRIEF.md
# Flash Command Decoder with Power-Down Abort

This block is the control core of a small NOR-style flash model. Bus writes taken while chip enable and write enable are both low are decoded into commands. A two-cycle setup-and-confirm sequence starts a word program or a whole-array erase on an internal write engine. The engine reports its progress through a ready output and through a status byte that is read back over the data bus. The storage is a small register array that can be built as block RAM, with per-word blank and damaged flags beside it.

An active-low power-down input works as a second, asynchronous-in-meaning reset that the block samples on the clock. While it is low, the block ignores every control input, blanks the read path, clears the status error bits and returns the decoder to array-read mode. If a program or erase is running, the input aborts it and leaves the words it touched damaged. When the input goes high again, a timed recovery window follows. The read path and the command input stay shut for that window.

After a program or erase, the decoder stays in status mode. Array data returns only after an explicit array-read command. Power-up is modelled by the synchronous reset, which also erases the array.

Top module: `flash_ctl`

## Requirements
- R1: After `rst`, `rdy` is 1, `dout_en` is 0 while no read is requested, and every word reads 0xFF in array mode with `dout_en` 1.
- R2: A write is taken only in a cycle where `ce_n` and `we_n` are both low. Writes with either one high change neither the decoder mode nor the array.
- R3: Command 0xFF selects array reads and 0x70 selects status reads. The status byte has bit 7 = ready (1 when idle), bit 5 = erase fail, bit 4 = program fail, bit 3 = program voltage low, and all other bits 0.
- R4: Command 0x40 followed by a write of address and data programs that word. The program takes exactly `T_PROG` busy cycles, and `rdy` is 0 during them. A setup cycle that is not followed by its second cycle changes nothing.
- R5: Command 0x20 followed by 0xD0 sets every word to 0xFF. Any other second byte sets status bits 5 and 4, starts nothing and leaves the array unchanged.
- R6: While an operation runs, `rdy` and status bit 7 read 0. Every command write except 0x70 is ignored.
- R7: When an operation ends, the decoder stays in status mode until 0xFF is written. Ending an operation never changes the mode.
- R8: A program or erase requested while `vpp_ok` is 0 starts nothing, leaves the array unchanged, and sets bit 3 plus bit 4 (program) or bit 5 (erase).
- R9: Command 0x50 clears status bits 5, 4 and 3 and leaves the mode unchanged.
- R10: While `pd_n` is low, `dout_en` is 0, all writes are ignored, status bits 5, 4 and 3 are cleared, and the decoder returns to array mode.
- R11: Driving `pd_n` low during a program makes the target word read 0x00. Driving it low during an erase makes every word read 0x00.
- R12: After `pd_n` rises, `dout_en` stays 0 and writes are ignored for `T_RECOV` cycles.
- R13: `dout_en` is 1 only when `ce_n` and `oe_n` were low on the preceding clock. Read data appears two clocks after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pd_n | input | 1 | Reset / power-down, active low |
| addr | input | AW | Word address |
| din | input | 8 | Write data / command byte |
| vpp_ok | input | 1 | Program voltage valid |
| dout | output | 8 | Read data (array word or status byte) |
| dout_en | output | 1 | Output driver enable; 0 means high impedance |
| rdy | output | 1 | 1 when no operation runs |

## Verification
Every address is programmed with its own arithmetic pattern and read back. This catches address aliasing and measures the exact busy length of each program. Command sequences are then varied: legal pairs, a wrong confirm byte, low program voltage, writes with only one strobe low, and writes issued while busy. Each is followed by a status read and an array read, so a wrong mode can be told apart from wrong data. Power-down is applied in the middle of a program, in the middle of an erase, and while a setup is pending. The read enable and the first writes after power-down are observed across the recovery window.

// File: rtl/flash_pkg.sv
package flash_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    M_ARRAY  = 2'd0,
    M_STATUS = 2'd1,
    M_PSETUP = 2'd2,
    M_ESETUP = 2'd3
  } mode_e;

  localparam logic [DW-1:0] CMD_READ  = 8'hFF;
  localparam logic [DW-1:0] CMD_STAT  = 8'h70;
  localparam logic [DW-1:0] CMD_CLR   = 8'h50;
  localparam logic [DW-1:0] CMD_PROG  = 8'h40;
  localparam logic [DW-1:0] CMD_ERASE = 8'h20;
  localparam logic [DW-1:0] CMD_CONF  = 8'hD0;
  localparam logic [DW-1:0] SPOILED   = 8'h00;

  localparam int ST_RDY  = 7;
  localparam int ST_EERR = 5;
  localparam int ST_PERR = 4;
  localparam int ST_VPP  = 3;
endpackage

// File: rtl/flash_cmd.sv
module flash_cmd
  import flash_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          pd_n,
  input  logic          wr,
  input  logic [DW-1:0] din,
  input  logic          busy,
  output mode_e         mode,
  output logic          req_prog,
  output logic          req_erase,
  output logic          seq_err,
  output logic          clr_err
);
  mode_e mode_d;

  always_comb begin
    mode_d    = mode;
    req_prog  = 1'b0;
    req_erase = 1'b0;
    seq_err   = 1'b0;
    clr_err   = 1'b0;
    if (wr) begin
      if (busy) begin
        if (din == CMD_STAT) mode_d = M_STATUS;
      end else begin
        case (mode)
          M_PSETUP: begin
            req_prog = 1'b1;
            mode_d   = M_STATUS;
          end
          M_ESETUP: begin
            if (din == CMD_CONF) req_erase = 1'b1;
            else                 seq_err   = 1'b1;
            mode_d = M_STATUS;
          end
          default: begin
            case (din)
              CMD_READ:  mode_d  = M_ARRAY;
              CMD_STAT:  mode_d  = M_STATUS;
              CMD_CLR:   clr_err = 1'b1;
              CMD_PROG:  mode_d  = M_PSETUP;
              CMD_ERASE: mode_d  = M_ESETUP;
              default:   ;
            endcase
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !pd_n) mode <= M_ARRAY;
    else              mode <= mode_d;
  end

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pd_n) && !$past(wr)) |-> $stable(mode));

  // R7
  done_keeps_mode_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && $past(pd_n) && !$past(rst)) |-> $stable(mode));
endmodule

// File: rtl/flash_wsm.sv
module flash_wsm
  import flash_pkg::*;
#(
  parameter int AW      = 4,
  parameter int T_PROG  = 6,
  parameter int T_ERASE = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pd_n,
  input  logic          vpp_ok,
  input  logic          req_prog,
  input  logic          req_erase,
  input  logic          seq_err,
  input  logic          clr_err,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          busy,
  output logic [7:0]    status,
  output logic          commit_prog,
  output logic          commit_erase,
  output logic          spoil_one,
  output logic          spoil_all,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data
);
  localparam int TMAX = (T_PROG > T_ERASE) ? T_PROG : T_ERASE;
  localparam int CW   = $clog2(TMAX + 1);

  logic [CW-1:0] cnt;
  logic          is_erase;
  logic          e_erase, e_prog, e_vpp;
  logic          last;

  assign last         = busy && (cnt == CW'(1));
  assign commit_prog  = pd_n && last && !is_erase;
  assign commit_erase = pd_n && last && is_erase;
  assign spoil_one    = !pd_n && busy && !is_erase;
  assign spoil_all    = !pd_n && busy && is_erase;
  assign status       = {!busy, 1'b0, e_erase, e_prog, e_vpp, 3'b000};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      is_erase <= 1'b0;
      op_addr  <= '0;
      op_data  <= '0;
      e_erase  <= 1'b0;
      e_prog   <= 1'b0;
      e_vpp    <= 1'b0;
    end else if (!pd_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      e_erase <= 1'b0;
      e_prog  <= 1'b0;
      e_vpp   <= 1'b0;
    end else begin
      if (busy) begin
        if (last) busy <= 1'b0;
        cnt <= cnt - 1'b1;
      end else if (req_prog) begin
        if (vpp_ok) begin
          busy     <= 1'b1;
          cnt      <= CW'(T_PROG);
          is_erase <= 1'b0;
          op_addr  <= addr;
          op_data  <= data;
        end else begin
          e_vpp  <= 1'b1;
          e_prog <= 1'b1;
        end
      end else if (req_erase) begin
        if (vpp_ok) begin
          busy     <= 1'b1;
          cnt      <= CW'(T_ERASE);
          is_erase <= 1'b1;
        end else begin
          e_vpp   <= 1'b1;
          e_erase <= 1'b1;
        end
      end
      if (seq_err) begin
        e_erase <= 1'b1;
        e_prog  <= 1'b1;
      end
      if (clr_err) begin
        e_erase <= 1'b0;
        e_prog  <= 1'b0;
        e_vpp   <= 1'b0;
      end
    end
  end

  // R6
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (req_prog || req_erase) |-> !busy);

  // R8
  vpp_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (pd_n && req_prog && !vpp_ok) |=> (!busy && status[ST_VPP] && status[ST_PERR]));

  // R10
  pd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !pd_n |=> (!busy && status[5:3] == 3'b000));
endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          wipe,
  input  logic          spoil_one,
  input  logic          spoil_all,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DW-1:0]    mem_q;
  logic [DEPTH-1:0] blank, bad;
  logic             blank_q, bad_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wdata;
    mem_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blank   <= '1;
      bad     <= '0;
      blank_q <= 1'b1;
      bad_q   <= 1'b0;
    end else begin
      if (wipe) begin
        blank <= '1;
        bad   <= '0;
      end else if (spoil_all) begin
        bad <= '1;
      end else begin
        if (wr_en) begin
          blank[waddr] <= 1'b0;
          bad[waddr]   <= 1'b0;
        end
        if (spoil_one) bad[waddr] <= 1'b1;
      end
      blank_q <= blank[raddr];
      bad_q   <= bad[raddr];
    end
  end

  assign rdata = bad_q ? SPOILED : (blank_q ? '1 : mem_q);

  // R11
  spoil_all_chk: assert property (@(posedge clk) disable iff (rst)
    (spoil_all && !wipe) |=> (&bad));

  // R5
  wipe_chk: assert property (@(posedge clk) disable iff (rst)
    wipe |=> ((&blank) && bad == '0));
endmodule

// File: rtl/flash_ctl.sv
module flash_ctl
  import flash_pkg::*;
#(
  parameter int  DEPTH   = 16,
  parameter int  T_PROG  = 6,
  parameter int  T_ERASE = 20,
  parameter int  T_RECOV = 15,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          pd_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic          vpp_ok,
  output logic [7:0]    dout,
  output logic          dout_en,
  output logic          rdy
);
  localparam int RW = $clog2(T_RECOV + 1);

  logic [RW-1:0] rc;
  logic          rec_ok, wr, rd;
  mode_e         mode;
  logic          req_prog, req_erase, seq_err, clr_err;
  logic          busy;
  logic [7:0]    status;
  logic          commit_prog, commit_erase, spoil_one, spoil_all;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data, arr_q, stat_q;
  logic          sel_arr_q, rd_q;

  always_ff @(posedge clk) begin
    if (rst)            rc <= '0;
    else if (!pd_n)     rc <= RW'(T_RECOV);
    else if (rc != '0)  rc <= rc - 1'b1;
  end

  assign rec_ok = (rc == '0);
  assign wr     = !ce_n && !we_n && pd_n && rec_ok;
  assign rd     = !ce_n && !oe_n && pd_n && rec_ok;
  assign rdy    = status[ST_RDY];

  flash_cmd u_cmd (
    .clk, .rst, .pd_n, .wr, .din, .busy, .mode,
    .req_prog, .req_erase, .seq_err, .clr_err
  );

  flash_wsm #(.AW(AW), .T_PROG(T_PROG), .T_ERASE(T_ERASE)) u_wsm (
    .clk, .rst, .pd_n, .vpp_ok, .req_prog, .req_erase, .seq_err, .clr_err,
    .addr, .data(din), .busy, .status, .commit_prog, .commit_erase,
    .spoil_one, .spoil_all, .op_addr, .op_data
  );

  flash_array #(.DEPTH(DEPTH), .AW(AW)) u_arr (
    .clk, .rst, .wr_en(commit_prog), .waddr(op_addr), .wdata(op_data),
    .wipe(commit_erase), .spoil_one, .spoil_all, .raddr(addr), .rdata(arr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_arr_q <= 1'b1;
      stat_q    <= '0;
      rd_q      <= 1'b0;
      dout      <= '0;
      dout_en   <= 1'b0;
    end else begin
      sel_arr_q <= (mode == M_ARRAY);
      stat_q    <= status;
      rd_q      <= rd;
      dout      <= sel_arr_q ? arr_q : stat_q;
      dout_en   <= rd_q && rd;
    end
  end

  // R10
  pd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !pd_n |=> !dout_en);

  // R12
  recov_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_n) |=> !dout_en);

  // R13
  read_en_chk: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> (!$past(ce_n) && !$past(oe_n)));
endmodule

// File: tb/sim_flash_ctl.sv
module sim_flash_ctl;
  localparam int DEPTH   = 16;
  localparam int T_PROG  = 6;
  localparam int T_ERASE = 20;
  localparam int T_RECOV = 15;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, pd_n = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] din = '0;
  logic       vpp_ok = 1'b1;
  logic [7:0] dout;
  logic       dout_en, rdy;

  int nchk = 0;
  int nbad = 0;
  bit done = 0;
  logic [7:0] exp_mem [DEPTH];

  always #10 clk = ~clk;

  flash_ctl #(.DEPTH(DEPTH), .T_PROG(T_PROG), .T_ERASE(T_ERASE), .T_RECOV(T_RECOV)) u0 (
    .clk, .rst, .ce_n, .we_n, .oe_n, .pd_n, .addr, .din, .vpp_ok,
    .dout, .dout_en, .rdy
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + 7) & 255);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wraw(input logic c, input logic w, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = c; we_n = w; addr = a; din = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic wcyc(input logic [3:0] a, input logic [7:0] d);
    wraw(1'b0, 1'b0, a, d);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v, output logic en);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; addr = a;
    repeat (3) @(negedge clk);
    v = dout; en = dout_en;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (rdy !== 1'b1 && n < 300) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic read_all(input string tag);
    logic [7:0] v;
    logic en;
    for (int a = 0; a < DEPTH; a++) begin
      rd(4'(a), v, en);
      chk({tag, " data"}, v, exp_mem[a]);
      chk({tag, " en"}, {7'b0, en}, 8'h01);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic en;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdy", {7'b0, rdy}, 8'h01);
    chk("R1 idle en", {7'b0, dout_en}, 8'h00);
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
    read_all("R1 blank");

    // R13 oe_n high gives no drive
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R13 oe high en", {7'b0, dout_en}, 8'h00);
    ce_n = 1'b1;

    // R4 program sweep with exact busy length, R7 status after completion
    for (int a = 0; a < DEPTH; a++) begin
      wcyc(4'd0, 8'h40);
      wcyc(4'(a), pat(a));
      chk("R4 busy at start", {7'b0, rdy}, 8'h00);
      wait_rdy(n);
      chk("R4 busy length", 8'(n), 8'(T_PROG));
      rd(4'(a), v, en);
      chk("R7 status after program", v, 8'h80);
      wcyc(4'd0, 8'hFF);
      exp_mem[a] = pat(a);
    end
    read_all("R4 sweep");

    // R2 one strobe high blocks writes
    wraw(1'b1, 1'b0, 4'd0, 8'h40);
    wraw(1'b1, 1'b0, 4'd2, 8'h11);
    wraw(1'b0, 1'b1, 4'd0, 8'h40);
    wraw(1'b0, 1'b1, 4'd2, 8'h11);
    rd(4'd2, v, en);
    chk("R2 blocked write", v, exp_mem[2]);

    // R3 status command
    wcyc(4'd0, 8'h70);
    rd(4'd9, v, en);
    chk("R3 status idle", v, 8'h80);
    wcyc(4'd0, 8'hFF);
    rd(4'd9, v, en);
    chk("R3 array again", v, exp_mem[9]);

    // R5 bad confirm, R9 clear
    wcyc(4'd0, 8'h20);
    wcyc(4'd0, 8'h33);
    rd(4'd0, v, en);
    chk("R5 sequence error", v, 8'hB0);
    wcyc(4'd0, 8'h50);
    rd(4'd0, v, en);
    chk("R9 cleared, still status", v, 8'h80);
    wcyc(4'd0, 8'hFF);
    rd(4'd1, v, en);
    chk("R5 array kept", v, exp_mem[1]);

    // R8 low program voltage
    vpp_ok = 1'b0;
    wcyc(4'd0, 8'h40);
    wcyc(4'd1, 8'h00);
    chk("R8 no busy", {7'b0, rdy}, 8'h01);
    rd(4'd0, v, en);
    chk("R8 program vpp", v, 8'h98);
    wcyc(4'd0, 8'h50);
    wcyc(4'd0, 8'h20);
    wcyc(4'd0, 8'hD0);
    rd(4'd0, v, en);
    chk("R8 erase vpp", v, 8'hA8);
    vpp_ok = 1'b1;
    wcyc(4'd0, 8'h50);
    wcyc(4'd0, 8'hFF);
    rd(4'd1, v, en);
    chk("R8 array kept", v, exp_mem[1]);

    // R6 erase with writes during busy
    wcyc(4'd0, 8'h20);
    wcyc(4'd0, 8'hD0);
    chk("R6 busy", {7'b0, rdy}, 8'h00);
    wcyc(4'd0, 8'hFF);
    wcyc(4'd0, 8'h20);
    rd(4'd0, v, en);
    chk("R6 status while busy", v, 8'h00);
    wait_rdy(n);
    rd(4'd0, v, en);
    chk("R7 status after erase", v, 8'h80);
    wcyc(4'd0, 8'hFF);
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
    read_all("R5 erased");

    for (int a = 3; a < 5; a++) begin
      wcyc(4'd0, 8'h40);
      wcyc(4'(a), pat(a));
      wait_rdy(n);
      exp_mem[a] = pat(a);
    end

    // R10/R11 abort a program while an error is latched
    vpp_ok = 1'b0;
    wcyc(4'd0, 8'h40);
    wcyc(4'd6, 8'h12);
    vpp_ok = 1'b1;
    wcyc(4'd0, 8'h40);
    wcyc(4'd3, 8'h77);
    pd_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; addr = 4'd4;
    repeat (3) @(negedge clk);
    chk("R10 no drive in power-down", {7'b0, dout_en}, 8'h00);
    ce_n = 1'b1; oe_n = 1'b1;
    wcyc(4'd0, 8'h40);
    wcyc(4'd5, 8'h11);
    chk("R10 abort ready", {7'b0, rdy}, 8'h01);
    @(negedge clk);
    pd_n = 1'b1;
    wcyc(4'd0, 8'h70);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; addr = 4'd3;
    repeat (T_RECOV + 3) @(negedge clk);
    chk("R12 en after recovery", {7'b0, dout_en}, 8'h01);
    chk("R11 program word spoiled", dout, 8'h00);
    ce_n = 1'b1; oe_n = 1'b1;
    exp_mem[3] = 8'h00;
    rd(4'd5, v, en);
    chk("R10 write in power-down ignored", v, 8'hFF);
    rd(4'd4, v, en);
    chk("R11 other word kept", v, exp_mem[4]);
    wcyc(4'd0, 8'h70);
    rd(4'd0, v, en);
    chk("R10 status cleared", v, 8'h80);
    wcyc(4'd0, 8'hFF);

    // R12 recovery window, R4 lone setup discarded
    wcyc(4'd0, 8'h40);
    @(negedge clk);
    pd_n = 1'b0;
    repeat (3) @(negedge clk);
    pd_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0; addr = 4'd4;
    repeat (T_RECOV) @(negedge clk);
    chk("R12 no drive in recovery", {7'b0, dout_en}, 8'h00);
    repeat (3) @(negedge clk);
    chk("R12 drive after recovery", {7'b0, dout_en}, 8'h01);
    chk("R12 data after recovery", dout, exp_mem[4]);
    ce_n = 1'b1; oe_n = 1'b1;
    wcyc(4'd4, 8'h00);
    rd(4'd4, v, en);
    chk("R4 lone setup discarded", v, exp_mem[4]);

    // R11 abort an erase
    wcyc(4'd0, 8'h20);
    wcyc(4'd0, 8'hD0);
    pd_n = 1'b0;
    repeat (3) @(negedge clk);
    pd_n = 1'b1;
    repeat (T_RECOV + 2) @(negedge clk);
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'h00;
    read_all("R11 erase spoiled");

    // R5 full erase recovers the array
    wcyc(4'd0, 8'h20);
    wcyc(4'd0, 8'hD0);
    wait_rdy(n);
    chk("R5 erase done", {7'b0, rdy}, 8'h01);
    wcyc(4'd0, 8'hFF);
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
    read_all("R5 re-erased");

    finish_run();
  end
endmodule